// File: doc/BRIEF.md
# Multiplexed ADC Channel Sequencer

This block runs an external successive-approximation converter and its analog input multiplexer so that a set of inputs is scanned with no processor involvement. A periodic sample-request strobe opens a scan. For each channel in turn, the block does the following:

- Drives the multiplexer select and waits a programmable number of cycles so the analog path can settle.
- Fires a single-cycle start-of-conversion pulse.
- Waits for the converter's end-of-conversion.
- Registers the result together with its channel number.
- Moves on to the next channel.

After the last channel has been converted, the block parks on channel 0. It stays idle until the next request.

Requests that land while a scan is still running are dropped, and a sticky overrun flag records them. If a conversion never reports completion within a programmable window, a sticky timeout flag is raised and the block abandons the scan.

Top module: `adc_scan_seq`

## Requirements
- R1: After a synchronous active-high reset, the block is idle: `busy`, `soc`, `res_valid`, `overrun` and `timeout` are 0, and `mux_sel` is 0.
- R2: An accepted request scans channels in the order 0, 1, 2 (`mux_sel` values 0, 1, 2). After channel 2 completes, `mux_sel` returns to 0 and the block goes idle; `mux_sel` never shows 3.
- R3: `soc` rises exactly SETTLE_CYC cycles after the cycle in which `mux_sel` takes the channel's value (for channel 0, the cycle after the request is sampled). `mux_sel` is held stable throughout that interval.
- R4: `soc` is high for exactly one clock per channel.
- R5: An end-of-conversion sampled while waiting for a result moves `mux_sel` to the next channel in the following cycle.
- R6: One cycle after the end-of-conversion is sampled, `res_valid` is high for one clock. At the same time `res_data` equals the 12-bit `adc_data` sampled with it, and `res_chan` equals the channel that was converted.
- R7: A request sampled while `busy` is high does not disturb the running scan, and it sets `overrun`, which stays 1 until reset.
- R8: If no end-of-conversion arrives within TIMEOUT_CYC cycles after `soc`, `timeout` becomes 1 (sticky until reset), `busy` drops, and `mux_sel` returns to 0. All of this is visible TIMEOUT_CYC cycles after `soc`.
- R9: An end-of-conversion sampled while the block is idle produces no `res_valid` and does not start a scan.
- R10: `busy` is high from the cycle after an accepted request until the cycle after the last channel's end-of-conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_req | input | 1 | Periodic scan request strobe |
| eoc | input | 1 | Converter end-of-conversion |
| adc_data | input | 12 | Converter result bus |
| mux_sel | output | 2 | Analog multiplexer select |
| soc | output | 1 | Start-of-conversion pulse |
| busy | output | 1 | Scan in progress |
| res_valid | output | 1 | Result strobe |
| res_data | output | 12 | Captured result |
| res_chan | output | 2 | Channel tag of the result |
| overrun | output | 1 | Sticky: request arrived during a scan |
| timeout | output | 1 | Sticky: conversion never completed |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have passed. They also assume `eoc` behaves as a converter would, so a channel step is only expected when the wait state and `eoc` coincide. The bench keeps to these assumptions:

- `eoc` is issued only after an observed `soc`, with a random latency well inside the timeout window.
- Extra requests are injected only during the conversion wait.
- The idle-time `eoc` and the timeout case are driven as separate directed scenarios.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_SETTLE = 2'd1,
      SQ_CONV   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/adc_scan_timer.sv
// Shared down-counter for the settling and the conversion-timeout windows.
module adc_scan_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (run && cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R3
   counter_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(load) && $past(cnt_q) == '0) |-> cnt_q == '0);
endmodule

// File: rtl/adc_scan_chan_ctr.sv
// Channel index register with wrap-around.
module adc_scan_chan_ctr #(
   parameter int NUM_CH = 3,
   parameter int CH_W   = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            clear,
   input  logic            step,
   output logic [CH_W-1:0] chan,
   output logic            last
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
   localparam bit POW2 = ((1 << CH_W) == NUM_CH);

   logic [CH_W-1:0] chan_q;
   logic [CH_W-1:0] chan_nxt;

   assign last = (chan_q == LAST_CH);

   generate
      if (POW2) begin : g_natural_wrap
         assign chan_nxt = chan_q + 1'b1;
      end else begin : g_compare_wrap
         assign chan_nxt = last ? '0 : chan_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || clear)
         chan_q <= '0;
      else if (step)
         chan_q <= chan_nxt;
   end

   assign chan = chan_q;

   // R2
   chan_range_chk: assert property (@(posedge clk) disable iff (rst)
      chan_q <= LAST_CH);
endmodule

// File: rtl/adc_scan_capture.sv
// Result register: data plus channel tag, with a one-cycle valid strobe.
module adc_scan_capture #(
   parameter int DATA_W = 12,
   parameter int CH_W   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic [DATA_W-1:0] data_in,
   input  logic [CH_W-1:0]   chan_in,
   output logic              valid,
   output logic [DATA_W-1:0] data,
   output logic [CH_W-1:0]   chan
);
   always_ff @(posedge clk) begin
      if (rst) begin
         valid <= 1'b0;
         data  <= '0;
         chan  <= '0;
      end else begin
         valid <= take;
         if (take) begin
            data <= data_in;
            chan <= chan_in;
         end
      end
   end

   // R6
   valid_single_chk: assert property (@(posedge clk) disable iff (rst)
      valid |=> (!valid || $past(take)));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NUM_CH      = 3,
   parameter int DATA_W      = 12,
   parameter int SETTLE_CYC  = 200,
   parameter int TIMEOUT_CYC = 1000,
   localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sample_req,
   input  logic              eoc,
   input  logic [DATA_W-1:0] adc_data,
   output logic [CH_W-1:0]   mux_sel,
   output logic              soc,
   output logic              busy,
   output logic              res_valid,
   output logic [DATA_W-1:0] res_data,
   output logic [CH_W-1:0]   res_chan,
   output logic              overrun,
   output logic              timeout
);
   import adc_scan_pkg::*;

   localparam int MAX_CYC = (SETTLE_CYC > TIMEOUT_CYC) ? SETTLE_CYC : TIMEOUT_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);
   localparam logic [CNT_W-1:0] SETTLE_LOAD = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] TMO_LOAD    = CNT_W'(TIMEOUT_CYC - 1);
   localparam logic [CH_W-1:0]  LAST_CH     = CH_W'(NUM_CH - 1);

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("adc_scan_seq: NUM_CH must be at least 2");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("adc_scan_seq: SETTLE_CYC must be at least 1");
      end
      if (TIMEOUT_CYC < 1) begin : g_bad_tmo
         $error("adc_scan_seq: TIMEOUT_CYC must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("adc_scan_seq: DATA_W must be at least 1");
      end
   endgenerate

   seq_state_t state_q;
   logic       soc_q;
   logic       ovr_q;
   logic       tmo_q;

   logic       expired;
   logic       last_ch;
   logic       accept;
   logic       settle_done;
   logic       eoc_hit;
   logic       tmo_hit;
   logic       tmr_load;
   logic       tmr_run;
   logic [CNT_W-1:0] tmr_val;

   assign accept      = (state_q == SQ_IDLE) && sample_req;
   assign settle_done = (state_q == SQ_SETTLE) && expired;
   assign eoc_hit     = (state_q == SQ_CONV) && eoc;
   assign tmo_hit     = (state_q == SQ_CONV) && !eoc && expired;

   assign tmr_load = accept || settle_done || (eoc_hit && !last_ch);
   assign tmr_val  = settle_done ? TMO_LOAD : SETTLE_LOAD;
   assign tmr_run  = (state_q != SQ_IDLE) && !tmr_load;

   adc_scan_timer #(.CNT_W(CNT_W)) timer_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .run      (tmr_run),
      .expired  (expired)
   );

   adc_scan_chan_ctr #(.NUM_CH(NUM_CH), .CH_W(CH_W)) chan_i (
      .clk   (clk),
      .rst   (rst),
      .clear (tmo_hit),
      .step  (eoc_hit),
      .chan  (mux_sel),
      .last  (last_ch)
   );

   adc_scan_capture #(.DATA_W(DATA_W), .CH_W(CH_W)) cap_i (
      .clk     (clk),
      .rst     (rst),
      .take    (eoc_hit),
      .data_in (adc_data),
      .chan_in (mux_sel),
      .valid   (res_valid),
      .data    (res_data),
      .chan    (res_chan)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SQ_IDLE;
         soc_q   <= 1'b0;
         ovr_q   <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         soc_q <= settle_done;
         if (sample_req && state_q != SQ_IDLE)
            ovr_q <= 1'b1;
         if (tmo_hit)
            tmo_q <= 1'b1;
         unique case (state_q)
            SQ_IDLE:   if (accept) state_q <= SQ_SETTLE;
            SQ_SETTLE: if (expired) state_q <= SQ_CONV;
            SQ_CONV: begin
               if (eoc)
                  state_q <= last_ch ? SQ_IDLE : SQ_SETTLE;
               else if (expired)
                  state_q <= SQ_IDLE;
            end
            default:   state_q <= SQ_IDLE;
         endcase
      end
   end

   assign soc     = soc_q;
   assign busy    = (state_q != SQ_IDLE);
   assign overrun = ovr_q;
   assign timeout = tmo_q;

   // R4
   soc_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
      soc |=> !soc);

   // R3
   settle_mux_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && state_q == SQ_SETTLE && $past(state_q) == SQ_SETTLE) |-> $stable(mux_sel));

   // R5
   eoc_advance_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(state_q) == SQ_CONV && $past(eoc)) |->
         mux_sel == (($past(mux_sel) == LAST_CH) ? '0 : $past(mux_sel) + 1'b1));

   // R6
   result_follows_eoc_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && res_valid) |-> $past(eoc));

   // R7
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(overrun)) |-> overrun);

   // R8
   timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $rose(timeout)) |-> (mux_sel == '0 && !busy));
endmodule

// File: tb/adc_scan_seq_tb_top.sv
module adc_scan_seq_tb_top;
   localparam int S_CYC = 6;
   localparam int T_CYC = 40;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        sample_req = 1'b0;
   logic        eoc = 1'b0;
   logic [11:0] adc_data = '0;
   logic [1:0]  mux_sel;
   logic        soc;
   logic        busy;
   logic        res_valid;
   logic [11:0] res_data;
   logic [1:0]  res_chan;
   logic        overrun;
   logic        timeout;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit exp_ovr = 1'b0;

   always #5 clk = ~clk;

   adc_scan_seq #(.NUM_CH(3), .DATA_W(12), .SETTLE_CYC(S_CYC), .TIMEOUT_CYC(T_CYC)) dut_i (
      .clk(clk), .rst(rst), .sample_req(sample_req), .eoc(eoc), .adc_data(adc_data),
      .mux_sel(mux_sel), .soc(soc), .busy(busy), .res_valid(res_valid),
      .res_data(res_data), .res_chan(res_chan), .overrun(overrun), .timeout(timeout));

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int next_ch(int c);
      return (c == 2) ? 0 : c + 1;
   endfunction

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=0", cycles);
         finish_run();
      end
   end

   // Wait from a driving negedge until soc is seen; checks gap and inputs.
   task automatic wait_soc(int ch, bit after_eoc, int exp_data, int exp_ch);
      int n = 0;
      forever begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            sample_req = 1'b0;
            eoc = 1'b0;
            chk("R10 busy during scan", busy, 1);
            chk("R5 mux_sel after step", mux_sel, ch);
            if (after_eoc) begin
               chk("R6 res_valid", res_valid, 1);
               chk("R6 res_data", res_data, exp_data);
               chk("R6 res_chan", res_chan, exp_ch);
            end
         end else if (after_eoc && n == 2) begin
            chk("R6 res_valid one cycle", res_valid, 0);
         end
         if (soc || n > S_CYC + 4) break;
         chk("R3 mux stable in settle", mux_sel, ch);
      end
      chk("R3 settle gap", n, S_CYC + 1);
      chk("R2 channel at soc", mux_sel, ch);
   endtask

   // One full scan; inj_ovr injects a mid-scan request on a random channel.
   task automatic do_scan(bit inj_ovr);
      int data, prev_data, prev_ch, lat, inj_ch;
      inj_ch = $urandom_range(2, 0);
      prev_data = 0;
      prev_ch = 0;
      sample_req = 1'b1;
      for (int ch = 0; ch < 3; ch++) begin
         wait_soc(ch, ch != 0, prev_data, prev_ch);
         lat = $urandom_range(7, 0);
         for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            sample_req = 1'b0;
            chk("R4 soc single pulse", soc, 0);
            if (inj_ovr && ch == inj_ch && i == 0) begin
               sample_req = 1'b1;
               exp_ovr = 1'b1;
            end
         end
         if (lat == 0) @(negedge clk);
         sample_req = 1'b0;
         data = $urandom_range(4095, 0);
         adc_data = 12'(data);
         eoc = 1'b1;
         prev_data = data;
         prev_ch = ch;
      end
      @(negedge clk);
      eoc = 1'b0;
      chk("R6 last res_valid", res_valid, 1);
      chk("R6 last res_data", res_data, prev_data);
      chk("R6 last res_chan", res_chan, 2);
      chk("R2 wrap to 0", mux_sel, next_ch(2));
      chk("R10 busy drops", busy, 0);
      chk("R7 overrun flag", overrun, int'(exp_ovr));
      chk("R8 no timeout", timeout, 0);
   endtask

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 busy", busy, 0);
      chk("R1 mux_sel", mux_sel, 0);
      chk("R1 soc", soc, 0);
      chk("R1 res_valid", res_valid, 0);
      chk("R1 overrun", overrun, 0);
      chk("R1 timeout", timeout, 0);

      // R9: eoc while idle
      eoc = 1'b1;
      adc_data = 12'hABC;
      @(negedge clk);
      eoc = 1'b0;
      chk("R9 no result when idle", res_valid, 0);
      chk("R9 stays idle", busy, 0);
      @(negedge clk);
      chk("R9 still idle", busy, 0);

      // Directed scan without overrun, then random scans
      do_scan(1'b0);
      repeat (4) @(negedge clk);
      for (int k = 0; k < 30; k++) begin
         do_scan(($urandom_range(3, 0) == 0));
         repeat ($urandom_range(5, 1)) @(negedge clk);
      end
      // Make sure overrun path is exercised at least once
      do_scan(1'b1);
      chk("R7 overrun set", overrun, 1);

      // R8: timeout
      @(negedge clk);
      sample_req = 1'b1;
      wait_soc(0, 1'b0, 0, 0);
      repeat (T_CYC - 1) @(negedge clk);
      chk("R8 not yet timed out", timeout, 0);
      chk("R8 still busy", busy, 1);
      @(negedge clk);
      chk("R8 timeout set", timeout, 1);
      chk("R8 idle", busy, 0);
      chk("R8 mux_sel 0", mux_sel, 0);
      repeat (3) @(negedge clk);
      chk("R8 timeout sticky", timeout, 1);

      // R1: reset clears sticky flags
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 overrun cleared", overrun, 0);
      chk("R1 timeout cleared", timeout, 0);
      exp_ovr = 1'b0;
      do_scan(1'b0);
      finish_run();
   end
endmodule